// File: doc/BRIEF.md
# Multiword DMA Request Handshake

This block sits on the device side of an IDE-style parallel bus and runs the request/acknowledge handshake for multiword DMA. A local controller arms it with a direction and a count of 16-bit words. Once armed, the block raises its request whenever the local buffer reports that it can take or supply data. It then waits for the host to assert the active-low acknowledge. Each completed host strobe in the programmed direction moves one word between the bus and a simple buffer port.

Transfers are grouped into bursts of at most `BURST_WORDS` words. At the end of a burst the request drops. The block waits for the host to release the acknowledge and for the buffer to be ready again, and then raises the request once more. When the last word has moved, the controller receives a one-cycle done pulse. A host strobe that completes while an operation is armed but the acknowledge is not asserted is reported as a protocol error. When no operation is armed, the acknowledge and both strobes are ignored.

Host strobes are active low and already synchronous to `clk`. A word completes on the trailing (rising) edge of a strobe, which is seen one clock after the strobe goes high relative to the previous sample.

Top module: `mdma_handshake`

## Requirements
- R1: While `rstN` is low and after reset, `dmaReq`, `doneP`, `errPulse`, `bufRdEn` and `bufWrEn` are all 0.
- R2: A `startP` pulse while idle with a nonzero `wordCount` arms the block. A `startP` pulse with a `wordCount` of 0 is ignored. While the block is armed, `dmaReq` rises only once `bufReady` is 1.
- R3: Once raised, `dmaReq` stays high until a word completes with `dmaAckN` low. It never falls without the acknowledge having been asserted in the previous cycle.
- R4: A word moves on the rising edge of the strobe that matches the direction: `hostRdN` when `dirToHost`=1, `hostWrN` when `dirToHost`=0. The strobe must complete while `dmaAckN`=0 and the request is up.
  - For a write, `bufWrEn` pulses for one cycle carrying the last `hostDataIn` sampled while `hostWrN` was low.
  - For a read, `hostDataOut` shows `bufRdData`, and `bufRdEn` pulses for one cycle to advance the buffer.
  - A strobe of the opposite direction moves nothing.
- R5: After `BURST_WORDS` words in one burst, with words still remaining, `dmaReq` falls. It stays low until `dmaAckN` returns high, and it rises again once `bufReady` is 1.
- R6: When the last programmed word moves, `doneP` is 1 for exactly one cycle, in the cycle after the completing strobe edge. In that cycle `dmaReq` is 0, and `dmaReq` stays 0 afterwards until a new start.
- R7: A strobe completion while the block is armed and `dmaAckN` is high makes `errPulse` 1 for one cycle, in the cycle after the edge. No word moves.
- R8: While idle, `dmaAckN` (including unknown values) and both strobes are ignored: there is no buffer access, no `errPulse` and no `dmaReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startP | input | 1 | Controller start pulse |
| dirToHost | input | 1 | 1: device to host (read), 0: host to device (write) |
| wordCount | input | CNT_W | Number of 16-bit words to move |
| bufReady | input | 1 | Buffer can supply or accept data |
| dmaReq | output | 1 | DMA request to host |
| dmaAckN | input | 1 | DMA acknowledge from host, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostDataIn | input | DATA_W | Bus data from host |
| hostDataOut | output | DATA_W | Bus data to host (0 unless a read is armed) |
| bufRdEn | output | 1 | Buffer read advance |
| bufRdData | input | DATA_W | Buffer read data |
| bufWrEn | output | 1 | Buffer write enable |
| bufWrData | output | DATA_W | Buffer write data |
| doneP | output | 1 | One-cycle completion pulse |
| errPulse | output | 1 | One-cycle protocol error pulse |

## Verification
The bench drives the acknowledge and both strobes while the block is idle, and also with unknown values on the acknowledge. A design that failed to gate on the armed state would touch the buffer or raise an error pulse. It holds the request up for many cycles without an acknowledge: a design that timed out or dropped the request early would be caught. It then runs a read longer than one burst and keeps the acknowledge low after the burst ends. This exposes a design that re-raises the request too early or loses count across bursts. It also issues a strobe without the acknowledge and a strobe in the wrong direction. A design that counted either of these as a word would finish with the wrong data order or report done too early.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic wordRd;
    logic wordWr;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_REQ,
    ST_DRAIN
  } hsState_t;

endpackage

// File: rtl/mdma_ctrl.sv
module mdma_ctrl
  import mdma_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BURST_WORDS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startP,
  input  logic             dirToHost,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             bufReady,
  input  logic             dmaAckN,
  input  logic             hostRdN,
  input  logic             hostWrN,
  output logic             dmaReq,
  output logic             doneP,
  output logic             errPulse,
  output logic             rdPath,
  output dpStrobe_t        strb
);
  localparam int BC_W = $clog2(BURST_WORDS + 1);

  hsState_t         state;
  logic [CNT_W-1:0] remaining;
  logic [BC_W-1:0]  burstCnt;
  logic             dirRdQ;
  logic             prevRdN, prevWrN;
  logic             rdEdge, wrEdge, dirEdge, anyEdge, ackOn, active;
  logic             wordMove, lastWord, burstFull;

  assign ackOn     = (dmaAckN == 1'b0);
  assign active    = (state != ST_IDLE);
  assign rdEdge    = !prevRdN && hostRdN;
  assign wrEdge    = !prevWrN && hostWrN;
  assign anyEdge   = rdEdge || wrEdge;
  assign dirEdge   = dirRdQ ? rdEdge : wrEdge;
  assign wordMove  = (state == ST_REQ) && ackOn && dirEdge;
  assign lastWord  = (remaining == CNT_W'(1));
  assign burstFull = (burstCnt == BC_W'(BURST_WORDS - 1));

  assign dmaReq      = (state == ST_REQ);
  assign rdPath      = active && dirRdQ;
  assign strb.wordRd = wordMove && dirRdQ;
  assign strb.wordWr = wordMove && !dirRdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRdN <= 1'b1;
      prevWrN <= 1'b1;
    end else begin
      prevRdN <= hostRdN;
      prevWrN <= hostWrN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      burstCnt  <= '0;
      dirRdQ    <= 1'b0;
      doneP     <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      doneP    <= 1'b0;
      errPulse <= active && !ackOn && anyEdge;
      unique case (state)
        ST_IDLE: begin
          if (startP && (wordCount != '0)) begin
            remaining <= wordCount;
            dirRdQ    <= dirToHost;
            state     <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (bufReady) begin
            burstCnt <= '0;
            state    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (wordMove) begin
            remaining <= remaining - CNT_W'(1);
            burstCnt  <= burstCnt + BC_W'(1);
            if (lastWord) begin
              doneP <= 1'b1;
              state <= ST_IDLE;
            end else if (burstFull) begin
              state <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (!ackOn) state <= ST_ARM;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: request only falls after the acknowledge was seen
  a_r3_req_holds: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaReq) |-> $past(dmaAckN == 1'b0));

  // R6: done arrives with the request already down, right after it was up
  a_r6_done_req_low: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> (!dmaReq && $past(dmaReq)));

  // R7: an error is only flagged for a strobe without acknowledge
  a_r7_err_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(dmaAckN));

  // R8: idle never raises the request in the next cycle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> !dmaReq);

  // R5: burst counter never exceeds the burst limit while requesting
  a_r5_burst_bound: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (burstCnt < BC_W'(BURST_WORDS)));

endmodule

// File: rtl/mdma_datapath.sv
module mdma_datapath
  import mdma_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              rdPath,
  input  logic              hostWrN,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] bufRdData,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              bufRdEn,
  output logic              bufWrEn,
  output logic [DATA_W-1:0] bufWrData
);
  logic [DATA_W-1:0] wrCap;

  // hold the last word seen while the write strobe is low
  always_ff @(posedge clk) begin
    if (!rstN)         wrCap <= '0;
    else if (!hostWrN) wrCap <= hostDataIn;
  end

  assign bufWrEn     = strb.wordWr;
  assign bufWrData   = wrCap;
  assign bufRdEn     = strb.wordRd;
  assign hostDataOut = rdPath ? bufRdData : '0;

  // R4: one direction of buffer access per cycle
  a_r4_one_dir: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bufRdEn, bufWrEn}));

endmodule

// File: rtl/mdma_handshake.sv
module mdma_handshake
  import mdma_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int BURST_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startP,
  input  logic              dirToHost,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              bufReady,
  output logic              dmaReq,
  input  logic              dmaAckN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              bufRdEn,
  input  logic [DATA_W-1:0] bufRdData,
  output logic              bufWrEn,
  output logic [DATA_W-1:0] bufWrData,
  output logic              doneP,
  output logic              errPulse
);
  dpStrobe_t strb;
  logic      rdPath;

  mdma_ctrl #(.CNT_W(CNT_W), .BURST_WORDS(BURST_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .startP(startP), .dirToHost(dirToHost),
    .wordCount(wordCount), .bufReady(bufReady), .dmaAckN(dmaAckN),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .dmaReq(dmaReq), .doneP(doneP),
    .errPulse(errPulse), .rdPath(rdPath), .strb(strb)
  );

  mdma_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdPath(rdPath), .hostWrN(hostWrN),
    .hostDataIn(hostDataIn), .bufRdData(bufRdData), .hostDataOut(hostDataOut),
    .bufRdEn(bufRdEn), .bufWrEn(bufWrEn), .bufWrData(bufWrData)
  );

  // R1: nothing is asserted during reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !dmaReq && !doneP && !errPulse);

endmodule

// File: tb/mdma_handshake_tb.sv
module mdma_handshake_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int DATA_W = 16;
  localparam int BURST_WORDS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startP = 1'b0, dirToHost = 1'b0, bufReady = 1'b0;
  logic [CNT_W-1:0] wordCount = '0;
  logic dmaAckN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1;
  logic [DATA_W-1:0] hostDataIn = '0;
  logic [DATA_W-1:0] hostDataOut, bufRdData, bufWrData;
  logic dmaReq, bufRdEn, bufWrEn, doneP, errPulse;

  int total = 0, bad = 0;
  int rdIdx = 0, wrSeen = 0, rdSeen = 0, errSeen = 0, rdPushed = 0;
  logic [DATA_W-1:0] expW[$];
  logic [DATA_W-1:0] expR[$];
  logic [DATA_W-1:0] lastRd;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bufRdData = 16'hA000 + DATA_W'(rdIdx);

  mdma_handshake #(.CNT_W(CNT_W), .DATA_W(DATA_W), .BURST_WORDS(BURST_WORDS)) dut_i (
    .clk(clk), .rstN(rstN), .startP(startP), .dirToHost(dirToHost),
    .wordCount(wordCount), .bufReady(bufReady), .dmaReq(dmaReq),
    .dmaAckN(dmaAckN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .bufRdEn(bufRdEn),
    .bufRdData(bufRdData), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .doneP(doneP), .errPulse(errPulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the buffer port acts
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (errPulse) errSeen++;
      if (bufWrEn) begin
        wrSeen++;
        if (expW.size() == 0) check(0, "R4 unexpected write", int'(bufWrData), 0);
        else begin
          logic [DATA_W-1:0] e;
          e = expW.pop_front();
          check(bufWrData == e, "R4 write data", int'(bufWrData), int'(e));
        end
      end
      if (bufRdEn) begin
        rdSeen++;
        if (expR.size() == 0) check(0, "R4 unexpected read", int'(lastRd), 0);
        else begin
          logic [DATA_W-1:0] e;
          e = expR.pop_front();
          check(lastRd == e, "R4 read data", int'(lastRd), int'(e));
        end
        rdIdx++;
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: one host strobe; pushes the expected item when a word should move
  task automatic strobe(input bit isRd, input logic [DATA_W-1:0] d, input bit expMove);
    @(negedge clk);
    hostDataIn = d;
    if (isRd) hostRdN = 1'b0; else hostWrN = 1'b0;
    @(negedge clk);
    if (isRd) lastRd = hostDataOut;
    @(negedge clk);
    if (expMove) begin
      if (isRd) begin expR.push_back(16'hA000 + DATA_W'(rdPushed)); rdPushed++; end
      else expW.push_back(d);
    end
    hostRdN = 1'b1;
    hostWrN = 1'b1;
  endtask

  task automatic start(input bit toHost, input int cnt);
    @(negedge clk);
    startP = 1'b1; dirToHost = toHost; wordCount = CNT_W'(cnt);
    @(negedge clk);
    startP = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    check(!dmaReq && !doneP && !errPulse && !bufRdEn && !bufWrEn, "R1 reset outputs",
          {dmaReq, doneP, errPulse, bufRdEn, bufWrEn}, 0);
    rstN = 1'b1;
    cyc(2);
    check(!dmaReq && !doneP && !errPulse, "R1 after reset", {dmaReq, doneP, errPulse}, 0);

    // R8: idle ignores acknowledge (unknown and low) and strobes
    dmaAckN = 1'bx;
    strobe(1'b0, 16'h5555, 1'b0);
    dmaAckN = 1'b0;
    strobe(1'b0, 16'h6666, 1'b0);
    strobe(1'b1, 16'h0, 1'b0);
    cyc(2);
    check(errSeen == 0, "R8 idle error count", errSeen, 0);
    check(wrSeen == 0 && rdSeen == 0, "R8 idle buffer access", wrSeen + rdSeen, 0);
    check(!dmaReq, "R8 idle request", dmaReq, 0);
    dmaAckN = 1'b1;

    // R2: zero count ignored
    bufReady = 1'b1;
    start(1'b0, 0);
    cyc(4);
    check(!dmaReq, "R2 zero count start", dmaReq, 0);

    // R2: armed but buffer not ready
    bufReady = 1'b0;
    start(1'b0, 3);
    cyc(4);
    check(!dmaReq, "R2 waits for bufReady", dmaReq, 0);
    bufReady = 1'b1;
    cyc(2);
    check(dmaReq, "R2 request raised", dmaReq, 1);

    // R3: no timeout without acknowledge
    cyc(8);
    check(dmaReq, "R3 request held without ack", dmaReq, 1);

    // R7: strobe without acknowledge
    strobe(1'b0, 16'h7777, 1'b0);
    @(negedge clk);
    check(errPulse, "R7 error pulse", errPulse, 1);
    @(negedge clk);
    check(!errPulse && dmaReq, "R7 one cycle, request kept", {errPulse, dmaReq}, 1);

    // R4: wrong-direction strobe ignored, then three writes
    dmaAckN = 1'b0;
    strobe(1'b1, 16'h0, 1'b0);
    check(dmaReq, "R3 request held with ack, no word", dmaReq, 1);
    strobe(1'b0, 16'h1111, 1'b1);
    strobe(1'b0, 16'h2222, 1'b1);
    check(dmaReq, "R3 request held between words", dmaReq, 1);
    strobe(1'b0, 16'h3333, 1'b1);
    @(negedge clk);
    check(doneP && !dmaReq, "R6 done with request low", {doneP, dmaReq}, 2);
    @(negedge clk);
    check(!doneP, "R6 done one cycle", doneP, 0);
    cyc(3);
    check(!dmaReq, "R6 request stays low", dmaReq, 0);
    check(wrSeen == 3 && expW.size() == 0, "R4 write word count", wrSeen, 3);
    dmaAckN = 1'b1;

    // R5: read of six words across two bursts
    start(1'b1, 6);
    cyc(3);
    check(dmaReq, "R5 read request", dmaReq, 1);
    dmaAckN = 1'b0;
    for (int k = 0; k < BURST_WORDS; k++) strobe(1'b1, 16'h0, 1'b1);
    @(negedge clk);
    check(!dmaReq, "R5 burst end drops request", dmaReq, 0);
    cyc(4);
    check(!dmaReq, "R5 waits for ack release", dmaReq, 0);
    dmaAckN = 1'b1;
    cyc(3);
    check(dmaReq, "R5 request re-raised", dmaReq, 1);
    dmaAckN = 1'b0;
    strobe(1'b1, 16'h0, 1'b1);
    strobe(1'b1, 16'h0, 1'b1);
    @(negedge clk);
    check(doneP && !dmaReq, "R6 read done", {doneP, dmaReq}, 2);
    cyc(2);
    check(rdSeen == 6 && expR.size() == 0, "R4 read word count", rdSeen, 6);
    dmaAckN = 1'b1;

    // R8 again after completion
    strobe(1'b0, 16'h9999, 1'b0);
    cyc(2);
    check(wrSeen == 3 && !dmaReq, "R8 ignored after done", wrSeen, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule